// File: doc/BRIEF.md
# Multi-Stream Prefetch Address Sequencer

This block produces cache-line request addresses for up to four independent prefetch streams. Software or a core front end programs a stream with a start byte address, the number of 16-byte quad words in each unit, the number of units, and a signed byte distance between the first bytes of consecutive units. The engine then walks that pattern and hands out one request per quad word. Each request carries the stream's store-intent flag and a replacement hint. A temporal stream asks for most-recently-used placement, and a transient stream asks for least-recently-used placement.

Commands enter on a valid/ready port, and the block always accepts them. A command starts a stream in a named slot, stops one slot, or stops every slot. Starting a slot that is still running throws away what that slot had left to issue and begins the new pattern. Active slots share the request port in round-robin order. The port issues at most one request per cycle, and only when the downstream side is ready. A busy vector shows which slots still have requests to issue. The block never faults, and its addresses wrap at 2^32.

Top module: `stream_prefetcher`

## Requirements
- R1: After synchronous reset the busy vector is 0, `req_valid` is low and `cmd_ready` is high.
- R2: Within one unit a stream issues `unit_qw` requests at the unit's base address plus 0, 16, 32, ... bytes. The address has no alignment requirement.
- R3: After the last quad word of a unit, the next unit's base is the previous base plus the sign-extended 16-bit stride, so a negative stride walks downward. Exactly `unit_count` units are issued.
- R4: A start command (`cmd_op`=0) with unit size 0 or unit count 0 issues no request and leaves the slot's busy bit clear.
- R5: Every request carries the stream's `cmd_store` value on `req_store`. `req_lru` is 1 for a transient stream (`cmd_transient`=1) and 0 for a temporal one.
- R6: Address arithmetic wraps modulo 2^32.
- R7: Eligible slots are served round-robin, one request per accepted cycle. After reset the search starts at slot 0.
- R8: A stop command (`cmd_op`=1) clears the named slot's busy bit on the next clock edge. That slot issues no request in the command cycle or afterwards.
- R9: A stop-all command (`cmd_op`=2) clears every busy bit on the next edge, and `req_valid` is low in the command cycle. `cmd_op`=3 has no effect.
- R10: A start command to an active slot drops the slot's remaining requests. The next request from that slot is the first address of the new pattern.
- R11: While `req_valid` is high and `req_ready` is low, with no command, the request stays valid and its fields stay stable.
- R12: A slot's busy bit stays set until the clock edge that accepts its last request, and it is clear after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always high) |
| cmd_op | input | 2 | 0 start, 1 stop slot, 2 stop all, 3 no operation |
| cmd_slot | input | 2 | Target slot |
| cmd_addr | input | 32 | Start byte address |
| cmd_unit_qw | input | 5 | Quad words per unit (0..31) |
| cmd_units | input | 8 | Number of units (0..255) |
| cmd_stride | input | 16 | Signed byte distance between unit bases |
| cmd_store | input | 1 | Store intent |
| cmd_transient | input | 1 | Transient (1) or temporal (0) locality |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request accepted by downstream |
| req_addr | output | 32 | Quad-word request address |
| req_store | output | 1 | Store intent of the request |
| req_lru | output | 1 | 1 = least-recently-used hint, 0 = most-recently-used |
| busy | output | 4 | Per-slot stream still running |

## Verification
The checker assumes that downstream honours the valid/ready contract: once `req_valid` is raised, the only things that may withdraw it are a command or an acceptance. The stability rule is therefore written only for cycles with no command. The checker also assumes that `cmd_slot` names one of the four slots, which holds by width. The bench keeps `req_ready` low while it issues start commands, so every stream's first request is arbitrated from a known state. It sends at most one command per cycle and gives strides of at least 16 bytes in magnitude. These conditions keep each expected address list computable from the descriptor alone.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    OP_START    = 2'd0,
    OP_STOP     = 2'd1,
    OP_STOP_ALL = 2'd2,
    OP_NOP      = 2'd3
  } pf_op_e;
endpackage

// File: rtl/pf_slot.sv
module pf_slot #(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 5,
  parameter int CNT_W    = 8,
  parameter int STRIDE_W = 16,
  parameter int QW_BYTES = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                kill,
  input  logic                advance,
  input  logic [ADDR_W-1:0]   d_addr,
  input  logic [SIZE_W-1:0]   d_size,
  input  logic [CNT_W-1:0]    d_count,
  input  logic [STRIDE_W-1:0] d_stride,
  input  logic                d_store,
  input  logic                d_lru,
  output logic                active,
  output logic [ADDR_W-1:0]   cur_addr,
  output logic                store,
  output logic                lru
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(QW_BYTES);

  logic [ADDR_W-1:0]   base_q;
  logic [SIZE_W-1:0]   size_q, qw_left;
  logic [CNT_W-1:0]    units_left;
  logic [STRIDE_W-1:0] stride_q;
  logic [ADDR_W-1:0]   next_base;

  assign next_base = base_q + {{(ADDR_W-STRIDE_W){stride_q[STRIDE_W-1]}}, stride_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      base_q     <= '0;
      cur_addr   <= '0;
      size_q     <= '0;
      qw_left    <= '0;
      units_left <= '0;
      stride_q   <= '0;
      store      <= 1'b0;
      lru        <= 1'b0;
    end else if (start) begin
      active     <= (d_size != '0) && (d_count != '0);
      base_q     <= d_addr;
      cur_addr   <= d_addr;
      size_q     <= d_size;
      qw_left    <= d_size;
      units_left <= d_count;
      stride_q   <= d_stride;
      store      <= d_store;
      lru        <= d_lru;
    end else if (kill) begin
      active <= 1'b0;
    end else if (advance && active) begin
      if (qw_left > SIZE_W'(1)) begin
        cur_addr <= cur_addr + STEP;
        qw_left  <= qw_left - SIZE_W'(1);
      end else if (units_left > CNT_W'(1)) begin
        base_q     <= next_base;
        cur_addr   <= next_base;
        qw_left    <= size_q;
        units_left <= units_left - CNT_W'(1);
      end else begin
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pf_rr_arb.sv
module pf_rr_arb #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         fire,
  output logic [N-1:0] gnt,
  output logic         any
);
  logic [IDX_W-1:0] last_q;
  logic [IDX_W-1:0] win;

  always_comb begin
    gnt = '0;
    win = last_q;
    any = 1'b0;
    for (int off = 1; off <= N; off++) begin
      int c;
      c = (int'(last_q) + off) % N;
      if (!any && req[c]) begin
        any    = 1'b1;
        gnt[c] = 1'b1;
        win    = IDX_W'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              last_q <= IDX_W'(N - 1);
    else if (fire && any) last_q <= win;
  end
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher #(
  parameter int N_SLOTS  = 4,
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 5,
  parameter int CNT_W    = 8,
  parameter int STRIDE_W = 16,
  parameter int QW_BYTES = 16,
  localparam int SLOT_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [1:0]          cmd_op,
  input  logic [SLOT_W-1:0]   cmd_slot,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [SIZE_W-1:0]   cmd_unit_qw,
  input  logic [CNT_W-1:0]    cmd_units,
  input  logic [STRIDE_W-1:0] cmd_stride,
  input  logic                cmd_store,
  input  logic                cmd_transient,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [ADDR_W-1:0]   req_addr,
  output logic                req_store,
  output logic                req_lru,
  output logic [N_SLOTS-1:0]  busy
);
  import pf_pkg::*;

  logic [N_SLOTS-1:0] start_v, kill_v, elig, gnt, adv;
  logic [ADDR_W-1:0]  addr_v [N_SLOTS];
  logic [N_SLOTS-1:0] store_v, lru_v;
  logic               any;

  assign cmd_ready = 1'b1;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    logic hit;
    assign hit        = cmd_valid && (cmd_slot == SLOT_W'(i));
    assign start_v[i] = hit && (pf_op_e'(cmd_op) == OP_START);
    assign kill_v[i]  = (hit && (pf_op_e'(cmd_op) == OP_STOP)) ||
                        (cmd_valid && (pf_op_e'(cmd_op) == OP_STOP_ALL));
    assign elig[i]    = busy[i] && !start_v[i] && !kill_v[i];
    assign adv[i]     = gnt[i] && req_ready;

    pf_slot #(
      .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W),
      .STRIDE_W(STRIDE_W), .QW_BYTES(QW_BYTES)
    ) u_slot (
      .clk(clk), .rst(rst),
      .start(start_v[i]), .kill(kill_v[i]), .advance(adv[i]),
      .d_addr(cmd_addr), .d_size(cmd_unit_qw), .d_count(cmd_units),
      .d_stride(cmd_stride), .d_store(cmd_store), .d_lru(cmd_transient),
      .active(busy[i]), .cur_addr(addr_v[i]),
      .store(store_v[i]), .lru(lru_v[i])
    );
  end

  pf_rr_arb #(.N(N_SLOTS)) u_arb (
    .clk(clk), .rst(rst), .req(elig), .fire(req_ready),
    .gnt(gnt), .any(any)
  );

  always_comb begin
    req_addr  = '0;
    req_store = 1'b0;
    req_lru   = 1'b0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (gnt[i]) begin
        req_addr  = req_addr | addr_v[i];
        req_store = req_store | store_v[i];
        req_lru   = req_lru | lru_v[i];
      end
    end
  end

  assign req_valid = any;
endmodule

// File: rtl/pf_chk.sv
module pf_chk #(
  parameter int N_SLOTS  = 4,
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 5,
  parameter int CNT_W    = 8,
  parameter int STRIDE_W = 16,
  localparam int SLOT_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic                cmd_valid,
  input logic [1:0]          cmd_op,
  input logic [SLOT_W-1:0]   cmd_slot,
  input logic [SIZE_W-1:0]   cmd_unit_qw,
  input logic [CNT_W-1:0]    cmd_units,
  input logic                req_valid,
  input logic                req_ready,
  input logic [ADDR_W-1:0]   req_addr,
  input logic                req_store,
  input logic                req_lru,
  input logic [N_SLOTS-1:0]  busy
);
  // R11
  hold_when_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !cmd_valid) |=>
      (req_valid && $stable(req_addr) && $stable(req_store) && $stable(req_lru)));

  // R8
  stop_clears_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd1) |=> !busy[$past(cmd_slot)]);

  // R9
  stop_all_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd2) |=> (busy == '0));

  // R9
  stop_all_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd2) |-> !req_valid);

  // R4
  empty_desc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd0 && (cmd_unit_qw == '0 || cmd_units == '0))
      |=> !busy[$past(cmd_slot)]);

  // R12
  req_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (busy != '0));
endmodule

bind stream_prefetcher pf_chk #(
  .N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
  .CNT_W(CNT_W), .STRIDE_W(STRIDE_W)
) u_chk (.*);

// File: tb/stream_prefetcher_test.sv
module stream_prefetcher_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid, cmd_ready;
  logic [1:0]  cmd_op, cmd_slot;
  logic [31:0] cmd_addr;
  logic [4:0]  cmd_unit_qw;
  logic [7:0]  cmd_units;
  logic [15:0] cmd_stride;
  logic        cmd_store, cmd_transient;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic        req_store, req_lru;
  logic [3:0]  busy;

  int total = 0;
  int fails = 0;
  logic [31:0] cap_addr [64];
  logic        cap_st [64];
  logic        cap_lru [64];
  logic [3:0]  cap_busy [64];
  int          got;

  always #10 clk = ~clk;

  stream_prefetcher uut (.*);

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'd3; cmd_slot = 2'd0;
    cmd_addr = '0; cmd_unit_qw = '0; cmd_units = '0; cmd_stride = '0;
    cmd_store = 1'b0; cmd_transient = 1'b0; req_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(logic [1:0] op, logic [1:0] slot, logic [31:0] a,
                      logic [4:0] sz, logic [7:0] n, logic [15:0] st,
                      logic s, logic t);
    cmd_valid = 1'b1; cmd_op = op; cmd_slot = slot; cmd_addr = a;
    cmd_unit_qw = sz; cmd_units = n; cmd_stride = st;
    cmd_store = s; cmd_transient = t;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd3;
  endtask

  task automatic collect(int n);
    got = 0;
    req_ready = 1'b1;
    for (int i = 0; i < 200 && got < n; i++) begin
      #1;
      if (req_valid) begin
        cap_addr[got] = req_addr; cap_st[got] = req_store;
        cap_lru[got] = req_lru; cap_busy[got] = busy;
        got++;
      end
      @(negedge clk);
    end
    req_ready = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    do_reset(); #1;
    chk(busy == 4'd0, "R1 busy", 32'(busy), 0);
    chk(!req_valid, "R1 req_valid", 32'(req_valid), 0);
    chk(cmd_ready, "R1 cmd_ready", 32'(cmd_ready), 1);
  endtask

  task automatic t_units();
    logic [31:0] b;
    do_reset();
    b = 32'h1000_0008;
    send(2'd0, 2'd2, b, 5'd2, 8'd3, 16'h0040, 1'b0, 1'b0);
    collect(6);
    chk(got == 6, "R3 count", 32'(got), 6);
    for (int u = 0; u < 3; u++)
      for (int q = 0; q < 2; q++) begin
        logic [31:0] e;
        e = b + 32'(u * 64) + 32'(q * 16);
        chk(cap_addr[u*2+q] == e, "R2 unit addr", cap_addr[u*2+q], e);
      end
    chk(cap_st[0] == 0 && cap_lru[0] == 0, "R5 temporal read flags",
        {cap_st[0], cap_lru[0]}, 0);
    chk(cap_busy[5] == 4'b0100, "R12 busy before last", 32'(cap_busy[5]), 4);
    chk(busy == 4'd0 && !req_valid, "R12 busy after last", 32'(busy), 0);
  endtask

  task automatic t_neg_stride();
    do_reset();
    send(2'd0, 2'd1, 32'h0000_0100, 5'd1, 8'd3, 16'hFFE0, 1'b1, 1'b1);
    collect(3);
    chk(cap_addr[0] == 32'h100, "R3 neg stride 0", cap_addr[0], 32'h100);
    chk(cap_addr[1] == 32'hE0, "R3 neg stride 1", cap_addr[1], 32'hE0);
    chk(cap_addr[2] == 32'hC0, "R3 neg stride 2", cap_addr[2], 32'hC0);
    chk(cap_st[1] == 1 && cap_lru[1] == 1, "R5 transient store flags",
        {cap_st[1], cap_lru[1]}, 3);
  endtask

  task automatic t_empty();
    do_reset();
    send(2'd0, 2'd0, 32'h40, 5'd0, 8'd5, 16'h10, 1'b0, 1'b0);
    send(2'd0, 2'd3, 32'h80, 5'd3, 8'd0, 16'h10, 1'b0, 1'b0);
    req_ready = 1'b1; #1;
    chk(busy == 4'd0, "R4 busy", 32'(busy), 0);
    chk(!req_valid, "R4 no request", 32'(req_valid), 0);
    req_ready = 1'b0;
  endtask

  task automatic t_wrap();
    do_reset();
    send(2'd0, 2'd0, 32'hFFFF_FFF0, 5'd2, 8'd1, 16'h10, 1'b0, 1'b0);
    collect(2);
    chk(cap_addr[0] == 32'hFFFF_FFF0, "R6 wrap first", cap_addr[0], 32'hFFFF_FFF0);
    chk(cap_addr[1] == 32'h0, "R6 wrap second", cap_addr[1], 0);
  endtask

  task automatic t_rr();
    do_reset();
    send(2'd0, 2'd1, 32'h3000, 5'd2, 8'd1, 16'h10, 1'b0, 1'b0);
    send(2'd0, 2'd0, 32'h2000, 5'd2, 8'd1, 16'h10, 1'b0, 1'b0);
    collect(4);
    chk(cap_addr[0] == 32'h2000, "R7 rr 0", cap_addr[0], 32'h2000);
    chk(cap_addr[1] == 32'h3000, "R7 rr 1", cap_addr[1], 32'h3000);
    chk(cap_addr[2] == 32'h2010, "R7 rr 2", cap_addr[2], 32'h2010);
    chk(cap_addr[3] == 32'h3010, "R7 rr 3", cap_addr[3], 32'h3010);
  endtask

  task automatic t_stall();
    logic [31:0] a0;
    do_reset();
    send(2'd0, 2'd0, 32'h700, 5'd2, 8'd1, 16'h10, 1'b0, 1'b0);
    #1; a0 = req_addr;
    repeat (3) @(negedge clk);
    #1;
    chk(req_valid && req_addr == 32'h700 && a0 == 32'h700, "R11 stall hold",
        req_addr, 32'h700);
  endtask

  task automatic t_stop();
    do_reset();
    send(2'd0, 2'd3, 32'h800, 5'd1, 8'd10, 16'h10, 1'b0, 1'b0);
    send(2'd0, 2'd2, 32'h900, 5'd1, 8'd10, 16'h10, 1'b0, 1'b0);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_slot = 2'd3; req_ready = 1'b1; #1;
    chk(req_valid && req_addr == 32'h900, "R8 stopped slot masked", req_addr, 32'h900);
    @(negedge clk); cmd_valid = 1'b0; cmd_op = 2'd3; req_ready = 1'b0; #1;
    chk(busy == 4'b0100, "R8 stop one", 32'(busy), 4);
    cmd_valid = 1'b1; cmd_op = 2'd3; @(negedge clk); cmd_valid = 1'b0; #1;
    chk(busy == 4'b0100, "R9 nop ignored", 32'(busy), 4);
    send(2'd2, 2'd0, 32'h0, 5'd0, 8'd0, 16'h0, 1'b0, 1'b0);
    #1;
    chk(busy == 4'd0 && !req_valid, "R9 stop all", 32'(busy), 0);
  endtask

  task automatic t_restart();
    do_reset();
    send(2'd0, 2'd1, 32'h5000, 5'd4, 8'd4, 16'h100, 1'b0, 1'b0);
    collect(2);
    chk(cap_addr[1] == 32'h5010, "R2 before restart", cap_addr[1], 32'h5010);
    send(2'd0, 2'd1, 32'h9000, 5'd1, 8'd1, 16'h10, 1'b1, 1'b0);
    collect(1);
    chk(cap_addr[0] == 32'h9000, "R10 restart addr", cap_addr[0], 32'h9000);
    chk(busy == 4'd0 && !req_valid, "R10 old remainder dropped", 32'(busy), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_units();
    t_neg_stride();
    t_empty();
    t_wrap();
    t_rr();
    t_stall();
    t_stop();
    t_restart();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule